// File: doc/BRIEF.md
# Uninitialized Address-Register Tracker

This block keeps one "initialized" flag for each entry of a 16-entry working register file and watches the CPU's register-file writes and address-pointer uses. A register becomes initialized only when it receives a full 16-bit word load. A byte write never initializes it, even when two byte writes together cover both halves. Register 15 is exempt and always counts as initialized. When an instruction uses a register as an address pointer before that register has been initialized, the block requests a device reset.

The same reset request is raised for an illegal opcode. An illegal opcode is either an instruction word whose upper 8 bits are 0x3F, or a word that the decoder marks as bad on its own input. The request is a single-cycle pulse, registered one clock after the offending input. Sticky cause flags record whether a pointer fault, an opcode fault, or both caused a request, and which register was involved. All state is cleared while the synchronous active-low system reset is held.

All inputs are event strobes sampled on every clock. The block always accepts them and never applies back-pressure, so no handshake is needed at its edge.

Top module: `urt_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `rst_req`, `fault_uninit`, `fault_opcode` and `fault_reg` are all zero. Every register except register 15 is uninitialized after reset.
- R2: A write with `wr_word`=1 marks the written register initialized from the next cycle on. A later pointer use of that register raises no request.
- R3: A write with `wr_word`=0 (a byte write) never initializes a register, even when two are made in a row. A byte write to an initialized register leaves it initialized.
- R4: Register 15 is never checked. Using it as a pointer raises no request, even when it has never been written.
- R5: There are two pointer ports, A and B, each with its own enable. A request fires when either enabled port names an uninitialized register. `fault_reg` then holds port A's index if A is at fault, and port B's index otherwise.
- R6: A pointer use in the same cycle as a word load to the same register is checked against the state before that load.
- R7: When `op_en`=1, an `op_word` whose bits [23:16] equal 0x3F raises a request and sets `fault_opcode`. So does `op_bad`=1 with `op_en`=1. Any other opcode byte raises no request.
- R8: `rst_req` is high for exactly one cycle. A violation in the cycle right after a request is not reported, so the request is never high on two cycles in a row.
- R9: `rst_req` rises in the cycle after the offending input. The flag for each cause that was present is set on that same edge, and the flags stay set until reset.
- R10: A pointer port whose enable is low is not checked, whatever its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Register-file write strobe |
| wr_idx | input | 4 | Index of the written register |
| wr_word | input | 1 | 1 = full word load, 0 = byte write |
| ptr_a_en | input | 1 | Pointer port A in use |
| ptr_a_idx | input | 4 | Register used as pointer on port A |
| ptr_b_en | input | 1 | Pointer port B in use |
| ptr_b_idx | input | 4 | Register used as pointer on port B |
| op_en | input | 1 | Instruction word presented |
| op_word | input | 24 | Instruction word |
| op_bad | input | 1 | Decoder marks the word illegal |
| rst_req | output | 1 | One-cycle reset request |
| fault_uninit | output | 1 | Sticky: a request came from an uninitialized pointer |
| fault_opcode | output | 1 | Sticky: a request came from an illegal opcode |
| fault_reg | output | 4 | Register index of the last pointer fault |

## Verification
The assertions assume that each strobe is a clean 0 or 1 in every cycle and that an index is meaningful only while its enable is high. They also assume that `rst_n` is held low for at least one clock before any check counts. The stimulus changes inputs one time unit after a rising edge and returns every strobe to zero between scenarios. It also starts each scenario from a fresh reset, so a request from one scenario cannot mask the next one through the single-pulse rule.

// File: rtl/urt_pkg.sv
package urt_pkg;
  localparam int URT_NREG     = 16;
  localparam int URT_EXEMPT   = 15;
  localparam int URT_IW       = 24;
  localparam int URT_OPW      = 8;
  localparam logic [7:0] URT_ILLEGAL_OP = 8'h3F;

  typedef struct packed {
    logic uninit;
    logic opcode;
  } urt_cause_t;
endpackage

// File: rtl/urt_valid_map.sv
module urt_valid_map #(
  parameter int NREG   = 16,
  parameter int EXEMPT = 15,
  localparam int IDXW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_word,
  output logic [NREG-1:0] vmap
);
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_flag
      if (g == EXEMPT) begin : g_fixed
        assign vmap[g] = 1'b1;
      end else begin : g_tracked
        logic flag_q;
        always_ff @(posedge clk) begin
          if (!rst_n) flag_q <= 1'b0;
          else if (wr_en && wr_word && (wr_idx == IDXW'(g))) flag_q <= 1'b1;
        end
        assign vmap[g] = flag_q;
      end
    end
  endgenerate

  AST_WORD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word) |=> vmap[$past(wr_idx)]); // R2

  AST_BYTE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && !vmap[wr_idx]) |=> !vmap[$past(wr_idx)]); // R3
endmodule

// File: rtl/urt_ptr_check.sv
module urt_ptr_check #(
  parameter int NREG  = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] vmap,
  input  logic            a_en,
  input  logic [IDXW-1:0] a_idx,
  input  logic            b_en,
  input  logic [IDXW-1:0] b_idx,
  output logic            hit,
  output logic [IDXW-1:0] bad_idx
);
  logic a_bad, b_bad;
  always_comb begin
    a_bad   = a_en && !vmap[a_idx];
    b_bad   = b_en && !vmap[b_idx];
    hit     = a_bad || b_bad;
    bad_idx = a_bad ? a_idx : b_idx;
  end
endmodule

// File: rtl/urt_op_screen.sv
module urt_op_screen #(
  parameter int IW  = 24,
  parameter int OPW = 8,
  parameter logic [OPW-1:0] ILLEGAL_OP = 8'h3F
) (
  input  logic          op_en,
  input  logic [IW-1:0] op_word,
  input  logic          op_bad,
  output logic          illegal
);
  logic [OPW-1:0] opc;
  always_comb begin
    opc     = op_word[IW-1 -: OPW];
    illegal = op_en && (op_bad || (opc == ILLEGAL_OP));
  end
endmodule

// File: rtl/urt_tracker.sv
module urt_tracker
  import urt_pkg::*;
#(
  parameter int NREG   = URT_NREG,
  parameter int EXEMPT = URT_EXEMPT,
  parameter int IW     = URT_IW,
  parameter int OPW    = URT_OPW,
  parameter logic [OPW-1:0] ILLEGAL_OP = URT_ILLEGAL_OP,
  localparam int IDXW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_word,
  input  logic            ptr_a_en,
  input  logic [IDXW-1:0] ptr_a_idx,
  input  logic            ptr_b_en,
  input  logic [IDXW-1:0] ptr_b_idx,
  input  logic            op_en,
  input  logic [IW-1:0]   op_word,
  input  logic            op_bad,
  output logic            rst_req,
  output logic            fault_uninit,
  output logic            fault_opcode,
  output logic [IDXW-1:0] fault_reg
);
  logic [NREG-1:0] vmap;
  logic            ptr_hit, op_ill, fire;
  logic [IDXW-1:0] bad_idx;
  urt_cause_t      cause_q;

  urt_valid_map #(.NREG(NREG), .EXEMPT(EXEMPT)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_word(wr_word), .vmap(vmap));

  urt_ptr_check #(.NREG(NREG)) u_ptr (
    .vmap(vmap), .a_en(ptr_a_en), .a_idx(ptr_a_idx), .b_en(ptr_b_en),
    .b_idx(ptr_b_idx), .hit(ptr_hit), .bad_idx(bad_idx));

  urt_op_screen #(.IW(IW), .OPW(OPW), .ILLEGAL_OP(ILLEGAL_OP)) u_op (
    .op_en(op_en), .op_word(op_word), .op_bad(op_bad), .illegal(op_ill));

  assign fire = (ptr_hit || op_ill) && !rst_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      cause_q   <= '0;
      fault_reg <= '0;
    end else begin
      rst_req <= fire;
      if (fire && ptr_hit) begin
        cause_q.uninit <= 1'b1;
        fault_reg      <= bad_idx;
      end
      if (fire && op_ill) cause_q.opcode <= 1'b1;
    end
  end

  assign fault_uninit = cause_q.uninit;
  assign fault_opcode = cause_q.opcode;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8

  AST_PTR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_hit && !rst_req) |=> (rst_req && fault_uninit)); // R5

  AST_OP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_word[IW-1 -: OPW] == ILLEGAL_OP && !rst_req) |=> (rst_req && fault_opcode)); // R7

  AST_EXEMPT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_a_en && ptr_a_idx == IDXW'(EXEMPT) && !ptr_b_en && !op_en) |=> !rst_req); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_uninit || fault_opcode) |=> ($stable(fault_uninit) || fault_uninit) && ($stable(fault_opcode) || fault_opcode)); // R9

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (fault_uninit || fault_opcode)); // R9
endmodule

// File: tb/sim_urt_tracker.sv
module sim_urt_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_word = 0, ptr_a_en = 0, ptr_b_en = 0, op_en = 0, op_bad = 0;
  logic [3:0] wr_idx = 0, ptr_a_idx = 0, ptr_b_idx = 0;
  logic [23:0] op_word = 0;
  logic rst_req, fault_uninit, fault_opcode;
  logic [3:0] fault_reg;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  urt_tracker u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .ptr_a_en(ptr_a_en), .ptr_a_idx(ptr_a_idx), .ptr_b_en(ptr_b_en),
    .ptr_b_idx(ptr_b_idx), .op_en(op_en), .op_word(op_word), .op_bad(op_bad),
    .rst_req(rst_req), .fault_uninit(fault_uninit), .fault_opcode(fault_opcode),
    .fault_reg(fault_reg));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    wr_en = 0; ptr_a_en = 0; ptr_b_en = 0; op_en = 0; op_bad = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] idx, input logic word);
    wr_en = 1; wr_idx = idx; wr_word = word;
    step();
    wr_en = 0;
  endtask

  task automatic ptr(input logic ae, input logic [3:0] a, input logic be, input logic [3:0] b);
    ptr_a_en = ae; ptr_a_idx = a; ptr_b_en = be; ptr_b_idx = b;
    step();
    ptr_a_en = 0; ptr_b_en = 0;
  endtask

  task automatic opc(input logic [23:0] w, input logic badf);
    op_en = 1; op_word = w; op_bad = badf;
    step();
    op_en = 0; op_bad = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; step();
    chk("R1 req in reset", rst_req, 0);
    do_reset();
    chk("R1 req after reset", rst_req, 0);
    chk("R1 uninit flag clear", fault_uninit, 0);
    chk("R1 opcode flag clear", fault_opcode, 0);
    chk("R1 fault_reg clear", fault_reg, 0);
    ptr(1, 4'd3, 0, 0);
    chk("R1 r3 uninit after reset", rst_req, 1);
  endtask

  task automatic t_word();
    do_reset();
    wr(4'd5, 1);
    ptr(1, 4'd5, 0, 0);
    chk("R2 word-loaded r5 ok", rst_req, 0);
    ptr(0, 0, 1, 4'd5);
    chk("R2 word-loaded r5 port B ok", rst_req, 0);
  endtask

  task automatic t_byte();
    do_reset();
    wr(4'd6, 0); wr(4'd6, 0);
    ptr(1, 4'd6, 0, 0);
    chk("R3 byte-only r6 req", rst_req, 1);
    chk("R3 uninit flag", fault_uninit, 1);
    chk("R3 fault_reg", fault_reg, 6);
    do_reset();
    wr(4'd9, 1); wr(4'd9, 0);
    ptr(1, 4'd9, 0, 0);
    chk("R3 byte after word keeps valid", rst_req, 0);
  endtask

  task automatic t_exempt();
    do_reset();
    ptr(1, 4'd15, 1, 4'd15);
    chk("R4 r15 exempt", rst_req, 0);
    chk("R4 no flag", fault_uninit, 0);
  endtask

  task automatic t_two_port();
    do_reset();
    wr(4'd1, 1);
    ptr(1, 4'd1, 1, 4'd2);
    chk("R5 port B fault req", rst_req, 1);
    chk("R5 port B fault_reg", fault_reg, 2);
    do_reset();
    ptr(1, 4'd4, 1, 4'd7);
    chk("R5 both bad req", rst_req, 1);
    chk("R5 port A priority", fault_reg, 4);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr_en = 1; wr_idx = 4'd8; wr_word = 1;
    ptr_a_en = 1; ptr_a_idx = 4'd8;
    step();
    wr_en = 0; ptr_a_en = 0;
    chk("R6 same-cycle use sees old state", rst_req, 1);
    step();
    ptr(1, 4'd8, 0, 0);
    chk("R6 r8 valid afterwards", rst_req, 0);
  endtask

  task automatic t_opcode();
    do_reset();
    opc(24'h3E1234, 0);
    chk("R7 opcode 3E legal", rst_req, 0);
    opc(24'h401234, 0);
    chk("R7 opcode 40 legal", rst_req, 0);
    opc(24'h3F0000, 0);
    chk("R7 opcode 3F req", rst_req, 1);
    chk("R7 opcode flag", fault_opcode, 1);
    chk("R7 uninit flag stays clear", fault_uninit, 0);
    do_reset();
    opc(24'h000000, 1);
    chk("R7 decoder bad req", rst_req, 1);
    do_reset();
    op_en = 0; op_word = 24'h3FFFFF; op_bad = 1;
    step(); op_bad = 0;
    chk("R7 no op_en no req", rst_req, 0);
  endtask

  task automatic t_pulse();
    do_reset();
    ptr_a_en = 1; ptr_a_idx = 4'd3;
    step();
    chk("R8 first req", rst_req, 1);
    step();
    chk("R8 next cycle low", rst_req, 0);
    step();
    chk("R8 re-fires after gap", rst_req, 1);
    ptr_a_en = 0;
    step();
  endtask

  task automatic t_sticky();
    do_reset();
    ptr_a_en = 1; ptr_a_idx = 4'd2;
    @(posedge clk); #1;
    ptr_a_en = 0;
    chk("R9 req one cycle after input", rst_req, 1);
    chk("R9 flag same edge", fault_uninit, 1);
    step(); step(); step();
    chk("R9 flag sticky", fault_uninit, 1);
    chk("R9 reg sticky", fault_reg, 2);
    do_reset();
    chk("R9 reset clears flag", fault_uninit, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    ptr_a_en = 0; ptr_a_idx = 4'd3; ptr_b_en = 0; ptr_b_idx = 4'd4;
    step();
    chk("R10 disabled ports no req", rst_req, 0);
    chk("R10 disabled ports no flag", fault_uninit, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_word();
    t_byte();
    t_exempt();
    t_two_port();
    t_same_cycle();
    t_opcode();
    t_pulse();
    t_sticky();
    t_disabled();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule